// File: doc/BRIEF.md
# Dual-Clock FIFO with Write-Side Reset Propagation

This block moves data words from a write clock domain to an unrelated read clock domain. Its only reset input belongs to the write domain. Pulsing that reset empties the whole queue. A reset indication also travels into the read domain, where it appears as a status output. The reader can therefore tell that every word it has not yet taken has been thrown away, and it can resynchronise its own protocol state.

The write and read positions are kept as Gray-coded counters that are one bit wider than the storage address. Each position reaches the other domain through a chain of two flops. In the read domain, every register that holds queue state is cleared asynchronously by the propagated reset. That reset rises at the moment the write reset rises, and it falls only after the write reset has been low for two read-clock edges. Word loss is therefore complete: nothing written before a reset can appear on the read side afterwards.

A parameter adds an output holding register in front of the read port. It works as a first-word-fall-through stage and adds one word of capacity.

Top module: `cfw_fifo`

## Requirements
- R1: `rd_rst_o` goes to 1 as soon as `wrst` goes to 1, including the initial reset. It returns to 0 only after `wrst` has been low for two rising `rclk` edges, so every `wrst` pulse produces a separate rise and fall on `rd_rst_o`.
- R2: `rd_rdy` is 0 whenever `rd_rst_o` is 1.
- R3: At the first rising `wclk` edge after `wrst` is released, `wr_rdy` is 1, whatever the queue held before the reset.
- R4: Words come out in the order they were written. While `rd_rdy` is 1, `rd_data` holds the oldest unread word. A word is consumed at a rising `rclk` edge where both `rd_en` and `rd_rdy` are 1.
- R5: With `OUT_REG` = 0 the capacity is 2**`AW` words (2 by default). When the queue is full, `wr_rdy` is 0 and a write attempted with `wr_en` = 1 is dropped.
- R6: When the queue is empty, `rd_rdy` is 0 and `rd_en` has no effect.
- R7: After a write reset, the first word presented on `rd_data` is the first word written after the reset. Nothing from before the reset is presented.
- R8: If a word is written and `wrst` is asserted on the very next write cycle, that word is lost. Once `rd_rst_o` has fallen, `rd_rdy` stays 0.
- R9: With `OUT_REG` = 1 the capacity is 2**`AW`+1 words (3 by default). A full queue shows `wr_rdy` = 0 and drops further writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst | input | 1 | Write-domain reset, active high; empties the queue |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| wr_rdy | output | 1 | Queue can accept a word |
| rclk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Oldest unread word, valid while rd_rdy is 1 |
| rd_rdy | output | 1 | A word is available |
| rd_rst_o | output | 1 | Propagated reset status in the read domain |

## Verification
The bench builds two copies side by side. Both use 32-bit words and `AW` = 1. One has no output register, giving a depth of 2. The other has `OUT_REG` = 1, giving a depth of 3. The small depths let the bench reach the full condition, the wrap of the pointer's extra bit and the dropped write within a handful of words. Every scenario runs under four clock relations: equal and aligned, equal and 180 degrees apart, a write clock five times faster than the read clock, and a read clock five times faster than the write clock. Under these relations the reset crossing meets both a slow and a fast sampling side.

// File: rtl/cfw_pkg.sv
`timescale 1ns/1ps
package cfw_pkg;

    // widest pointer the Gray helpers handle
    localparam int GW_MAX = 16;

    // state of the optional output holding register
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

    function automatic logic [GW_MAX-1:0] bin2gray(input logic [GW_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW_MAX-1:0] gray2bin(input logic [GW_MAX-1:0] g);
        logic [GW_MAX-1:0] b;
        b[GW_MAX-1] = g[GW_MAX-1];
        for (int i = GW_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/cfw_sync2.sv
`timescale 1ns/1ps
// Multi-flop synchronizer; reset style chosen by parameter.
module cfw_sync2 #(
    parameter int W         = 2,
    parameter int STAGES    = 2,
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        if (ASYNC_RST) begin : g_arst
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
        end else begin : g_srst
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfw_ptr.sv
`timescale 1ns/1ps
// Binary position counter with a registered Gray copy for crossing.
module cfw_ptr
    import cfw_pkg::*;
#(
    parameter int AW        = 1,
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        inc,
    output logic [AW:0] bin,
    output logic [AW:0] gray
);
    localparam int PW = AW + 1;

    logic [PW-1:0] bin_nx;
    logic [PW-1:0] gray_nx;

    assign bin_nx  = bin + PW'(inc);
    assign gray_nx = PW'(bin2gray(GW_MAX'(bin_nx)));

    generate
        if (ASYNC_RST) begin : g_arst
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    bin  <= '0;
                    gray <= '0;
                end else begin
                    bin  <= bin_nx;
                    gray <= gray_nx;
                end
            end
        end else begin : g_srst
            always_ff @(posedge clk) begin
                if (rst) begin
                    bin  <= '0;
                    gray <= '0;
                end else begin
                    bin  <= bin_nx;
                    gray <= gray_nx;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cfw_rst_bridge.sv
`timescale 1ns/1ps
// Carries the write reset into the read domain: immediate rise, synchronous fall.
module cfw_rst_bridge #(
    parameter int STAGES = 2
) (
    input  logic rclk,
    input  logic wrst,
    output logic rd_rst
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge rclk or posedge wrst) begin
        if (wrst) chain <= '1;
        else      chain <= {chain[STAGES-2:0], 1'b0};
    end

    assign rd_rst = chain[STAGES-1];
endmodule

// File: rtl/cfw_fifo.sv
`timescale 1ns/1ps
module cfw_fifo
    import cfw_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 1,
    parameter bit OUT_REG = 1'b0
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_rdy,
    input  logic          rclk,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_rdy,
    output logic          rd_rst_o
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rgray_w, rbin_w, wgray_r;
    logic          rd_rst;
    logic          w_full, w_push;
    logic          r_empty, r_pop;
    logic [DW-1:0] core_data;

    // ---------------- reset crossing ----------------
    cfw_rst_bridge #(.STAGES(2)) u_rst_bridge (
        .rclk   (rclk),
        .wrst   (wrst),
        .rd_rst (rd_rst)
    );
    assign rd_rst_o = rd_rst;

    // ---------------- write domain ----------------
    cfw_sync2 #(.W(PW), .STAGES(2), .ASYNC_RST(1'b0)) u_r2w (
        .clk (wclk),
        .rst (wrst),
        .d   (rgray),
        .q   (rgray_w)
    );

    assign rbin_w = PW'(gray2bin(GW_MAX'(rgray_w)));
    assign w_full = (wbin[AW] != rbin_w[AW]) && (wbin[AW-1:0] == rbin_w[AW-1:0]);
    assign wr_rdy = !w_full;
    assign w_push = wr_en && !w_full && !wrst;

    cfw_ptr #(.AW(AW), .ASYNC_RST(1'b0)) u_wptr (
        .clk  (wclk),
        .rst  (wrst),
        .inc  (w_push),
        .bin  (wbin),
        .gray (wgray)
    );

    always_ff @(posedge wclk) begin
        if (w_push) mem[wbin[AW-1:0]] <= wr_data;
    end

    // ---------------- read domain ----------------
    cfw_sync2 #(.W(PW), .STAGES(2), .ASYNC_RST(1'b1)) u_w2r (
        .clk (rclk),
        .rst (rd_rst),
        .d   (wgray),
        .q   (wgray_r)
    );

    assign r_empty   = (rgray == wgray_r);
    assign core_data = mem[rbin[AW-1:0]];

    cfw_ptr #(.AW(AW), .ASYNC_RST(1'b1)) u_rptr (
        .clk  (rclk),
        .rst  (rd_rst),
        .inc  (r_pop),
        .bin  (rbin),
        .gray (rgray)
    );

    generate
        if (OUT_REG) begin : g_buf
            slot_e         slot;
            logic [DW-1:0] hold;

            assign r_pop = !r_empty && ((slot == SLOT_EMPTY) || rd_en);

            always_ff @(posedge rclk or posedge rd_rst) begin
                if (rd_rst)      slot <= SLOT_EMPTY;
                else if (r_pop)  slot <= SLOT_FULL;
                else if (rd_en)  slot <= SLOT_EMPTY;
            end

            always_ff @(posedge rclk) begin
                if (r_pop) hold <= core_data;
            end

            assign rd_rdy  = (slot == SLOT_FULL);
            assign rd_data = hold;
        end else begin : g_direct
            assign r_pop   = rd_en && !r_empty;
            assign rd_rdy  = !r_empty;
            assign rd_data = core_data;
        end
    endgenerate
endmodule

// File: rtl/cfw_fifo_chk.sv
`timescale 1ns/1ps
module cfw_fifo_chk #(
    parameter int PW = 2
) (
    input logic          wclk,
    input logic          rclk,
    input logic          wrst,
    input logic          wr_rdy,
    input logic          rd_rdy,
    input logic          rd_rst_o,
    input logic          r_empty,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray
);
    p_rst_seen_r1: assert property (@(posedge rclk) wrst |-> rd_rst_o);

    p_no_rdy_in_rst_r2: assert property (@(posedge rclk) disable iff (wrst)
        rd_rst_o |-> !rd_rdy);

    p_ready_after_release_r3: assert property (@(posedge wclk) disable iff (wrst)
        $past(wrst) |-> wr_rdy);

    p_wgray_step_r4: assert property (@(posedge wclk) disable iff (wrst)
        !$past(wrst) |-> ($countones(wgray ^ $past(wgray)) <= 1));

    p_rgray_step_r4: assert property (@(posedge rclk) disable iff (rd_rst_o)
        !$past(rd_rst_o) |-> ($countones(rgray ^ $past(rgray)) <= 1));

    p_no_overflow_r5: assert property (@(posedge wclk) disable iff (wrst)
        !wr_rdy |=> $stable(wgray));

    p_no_underflow_r6: assert property (@(posedge rclk) disable iff (rd_rst_o)
        r_empty |=> $stable(rgray));
endmodule

bind cfw_fifo cfw_fifo_chk #(.PW(AW + 1)) u_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .wrst     (wrst),
    .wr_rdy   (wr_rdy),
    .rd_rdy   (rd_rdy),
    .rd_rst_o (rd_rst_o),
    .r_empty  (r_empty),
    .wgray    (wgray),
    .rgray    (rgray)
);

// File: tb/cfw_fifo_tb.sv
`timescale 1ns/1ps
module cfw_fifo_tb;
    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        wrst = 1'b0;
    logic [1:0]  wr_en = '0;
    logic [1:0]  rd_en = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  wr_rdy, rd_rdy, rd_rst;
    logic [31:0] rd_data [2];

    real wh = 2.5;
    real rh = 2.5;
    int  shift_req = 0;
    int  n_chk = 0;
    int  n_bad = 0;

    cfw_fifo #(.DW(32), .AW(1), .OUT_REG(1'b0)) u_dut (
        .wclk(wclk), .wrst(wrst), .wr_en(wr_en[0]), .wr_data(wr_data), .wr_rdy(wr_rdy[0]),
        .rclk(rclk), .rd_en(rd_en[0]), .rd_data(rd_data[0]), .rd_rdy(rd_rdy[0]),
        .rd_rst_o(rd_rst[0])
    );

    cfw_fifo #(.DW(32), .AW(1), .OUT_REG(1'b1)) u_dut_buf (
        .wclk(wclk), .wrst(wrst), .wr_en(wr_en[1]), .wr_data(wr_data), .wr_rdy(wr_rdy[1]),
        .rclk(rclk), .rd_en(rd_en[1]), .rd_data(rd_data[1]), .rd_rdy(rd_rdy[1]),
        .rd_rst_o(rd_rst[1])
    );

    initial begin
        #2;
        forever #(wh) wclk = ~wclk;
    end

    initial begin
        int done = 0;
        #2;
        forever begin
            if (done != shift_req) begin
                done = shift_req;
                #(rh);
            end
            #(rh) rclk = ~rclk;
        end
    end

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // write reset pulse of one write cycle
    task automatic wr_reset(input int sel);
        @(negedge wclk);
        wrst = 1'b1;
        #0.5;
        check(rd_rst[sel] == 1'b1, "R1 rd_rst_o rises with wrst", 32'(rd_rst[sel]), 32'd1);
        check(rd_rdy[sel] == 1'b0, "R2 rd_rdy low in reset", 32'(rd_rdy[sel]), 32'd0);
        @(negedge wclk);
        wrst = 1'b0;
        @(negedge wclk);
        check(wr_rdy[sel] == 1'b1, "R3 wr_rdy after release", 32'(wr_rdy[sel]), 32'd1);
        if (rd_rst[sel])
            check(rd_rdy[sel] == 1'b0, "R2 rd_rdy low in reset", 32'(rd_rdy[sel]), 32'd0);
    endtask

    task automatic wait_rd_out(input int sel);
        bit seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge rclk);
            if (!rd_rst[sel]) begin
                seen = 1'b1;
                break;
            end
            check(rd_rdy[sel] == 1'b0, "R2 rd_rdy low in reset", 32'(rd_rdy[sel]), 32'd0);
        end
        check(seen, "R1 rd_rst_o falls after release", 32'(rd_rst[sel]), 32'd0);
    endtask

    task automatic push(input int sel, input logic [31:0] d, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge wclk);
            if (wr_rdy[sel]) begin
                wr_en[sel] = 1'b1;
                wr_data = d;
                @(negedge wclk);
                wr_en[sel] = 1'b0;
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic pop(input int sel, output logic [31:0] d, output bit ok);
        ok = 1'b0;
        d = '0;
        for (int i = 0; i < 80; i++) begin
            @(negedge rclk);
            if (rd_rdy[sel]) begin
                d = rd_data[sel];
                rd_en[sel] = 1'b1;
                @(negedge rclk);
                rd_en[sel] = 1'b0;
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic idle_r(input int n);
        for (int i = 0; i < n; i++) @(negedge rclk);
    endtask

    task automatic idle_w(input int n);
        for (int i = 0; i < n; i++) @(negedge wclk);
    endtask

    // fill to capacity, try one more, drain in order
    task automatic t_fill_drain(input int sel);
        int cap = (sel == 0) ? 2 : 3;
        string cap_tag = (sel == 0) ? "R5" : "R9";
        bit ok;
        logic [31:0] got;
        for (int i = 0; i < cap; i++) begin
            push(sel, 32'h1A1A_0000 | 32'(i), ok);
            check(ok, {cap_tag, " write accepted below capacity"}, 32'(ok), 32'd1);
        end
        idle_w(40);
        check(wr_rdy[sel] == 1'b0, {cap_tag, " wr_rdy low when full"}, 32'(wr_rdy[sel]), 32'd0);
        @(negedge wclk);
        wr_en[sel] = 1'b1;
        wr_data = 32'hDEAD_BEEF;
        @(negedge wclk);
        wr_en[sel] = 1'b0;
        for (int i = 0; i < cap; i++) begin
            pop(sel, got, ok);
            check(ok && got == (32'h1A1A_0000 | 32'(i)), "R4 words in order", got,
                  32'h1A1A_0000 | 32'(i));
        end
        idle_r(12);
        check(rd_rdy[sel] == 1'b0, {cap_tag, " write while full dropped"}, 32'(rd_rdy[sel]), 32'd0);
    endtask

    // read on empty has no effect
    task automatic t_empty_read(input int sel);
        bit ok;
        logic [31:0] got;
        check(rd_rdy[sel] == 1'b0, "R6 empty after reset", 32'(rd_rdy[sel]), 32'd0);
        @(negedge rclk);
        rd_en[sel] = 1'b1;
        @(negedge rclk);
        rd_en[sel] = 1'b0;
        check(rd_rdy[sel] == 1'b0, "R6 rd_en ignored on empty", 32'(rd_rdy[sel]), 32'd0);
        push(sel, 32'h0E0E_0001, ok);
        pop(sel, got, ok);
        check(ok && got == 32'h0E0E_0001, "R6 no pointer slip after empty read", got, 32'h0E0E_0001);
    endtask

    // stale data discarded by a reset
    task automatic t_reset_refill(input int sel);
        bit ok;
        logic [31:0] got;
        push(sel, 32'hB0B0_0000, ok);
        push(sel, 32'hB0B0_0001, ok);
        idle_r(12);
        check(rd_rdy[sel] == 1'b1 && rd_data[sel] == 32'hB0B0_0000, "R4 head visible",
              rd_data[sel], 32'hB0B0_0000);
        wr_reset(sel);
        wait_rd_out(sel);
        check(rd_rdy[sel] == 1'b0, "R7 old content dropped", 32'(rd_rdy[sel]), 32'd0);
        push(sel, 32'hC0C0_0000, ok);
        push(sel, 32'hC0C0_0001, ok);
        pop(sel, got, ok);
        check(ok && got == 32'hC0C0_0000, "R7 first word after reset", got, 32'hC0C0_0000);
        pop(sel, got, ok);
        check(ok && got == 32'hC0C0_0001, "R4 second word after reset", got, 32'hC0C0_0001);
    endtask

    // write then reset on the very next cycle
    task automatic t_write_then_reset(input int sel);
        for (int i = 0; i < 400; i++) begin
            @(negedge wclk);
            if (wr_rdy[sel]) break;
        end
        wr_en[sel] = 1'b1;
        wr_data = 32'hD0D0_D0D0;
        @(negedge wclk);
        wr_en[sel] = 1'b0;
        wrst = 1'b1;
        #0.5;
        check(rd_rst[sel] == 1'b1, "R1 rd_rst_o rises again", 32'(rd_rst[sel]), 32'd1);
        @(negedge wclk);
        wrst = 1'b0;
        wait_rd_out(sel);
        idle_r(12);
        check(rd_rdy[sel] == 1'b0, "R8 word before reset lost", 32'(rd_rdy[sel]), 32'd0);
    endtask

    task automatic run_case(input int sel);
        wr_reset(sel);
        wait_rd_out(sel);
        t_empty_read(sel);
        t_fill_drain(sel);
        t_reset_refill(sel);
        t_write_then_reset(sel);
    endtask

    initial begin
        #1;
        wrst = 1'b1;
        #0.5;
        check(rd_rst[0] == 1'b1, "R1 power-up reset plain", 32'(rd_rst[0]), 32'd1);
        check(rd_rst[1] == 1'b1, "R1 power-up reset buffered", 32'(rd_rst[1]), 32'd1);
        idle_w(3);
        wrst = 1'b0;

        // equal clocks, aligned
        run_case(0);
        run_case(1);
        // equal clocks, 180 degrees apart
        shift_req = 1;
        idle_r(4);
        run_case(0);
        run_case(1);
        // write clock five times faster
        rh = 12.5;
        idle_r(4);
        run_case(0);
        run_case(1);
        // read clock five times faster
        wh = 12.5;
        rh = 2.5;
        idle_w(4);
        run_case(0);
        run_case(1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule